// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block keeps wall-clock time as a 32-bit seconds count and a nanoseconds count that always stays below one billion. Each reference clock cycle adds a fixed tick of nanoseconds while counting is enabled. When the nanoseconds pass one billion they wrap, and the seconds count carries. The current time is driven out on two wide buses for neighbouring timestamp and trigger logic.

Software controls the block through a 16-bit command register and a single shared 16-bit time-data register. Times go in and out of the data register as four 16-bit words. A word index selects which word the next access reaches. Word 0 is the low half of the nanoseconds, word 1 the high half of the nanoseconds, word 2 the low half of the seconds and word 3 the high half of the seconds.

A load command replaces the time with the staged words. A step command adds the staged words to the running time as a signed offset. A capture command freezes a copy of the time for reading back. A step runs through a small state machine:
- **IDLE** moves to **STEP_NS** on an accepted step command.
- **STEP_NS** applies the nanosecond offset and always moves to **STEP_SEC**.
- **STEP_SEC** applies the seconds offset and returns to **IDLE**.

The tick keeps being added during both step cycles, so no elapsed time is lost.

Top module: `ptp_tod_clock`

## Requirements
- R1: After reset the time is 0 s / 0 ns, counting is off, and the data read port shows 0.
- R2: While counting is on, every reference cycle adds 8 ns. While it is off, and no load or step is in progress, the time holds still.
- R3: The nanosecond count stays below 1,000,000,000. An addition that reaches or passes that value wraps it and adds one to the 32-bit seconds count, which itself wraps at 2^32.
- R4: Command bit 1 turns counting on and bit 0 turns it off. When both are set, off wins. A command word with any of bits 15..5 set is ignored, apart from its index reset (R5).
- R5: Each data write stores into, and each data read returns, the word at the current index. The word order is: index 0 = nanoseconds[15:0], index 1 = nanoseconds[31:16], index 2 = seconds[15:0], index 3 = seconds[31:16]. Every access advances the index, and it wraps from 3 to 0. Any command write clears the index to 0.
- R6: Command bit 3 (load) replaces the time with the staged words at the edge that accepts the command. Counting continues from the loaded value on the next cycle.
- R7: Command bit 2 (capture) latches the time as it stood before the accepting edge. Four reads then return that copy in the word order of R5, while the live time keeps running.
- R8: Command bit 4 (step) adds the staged words as a two's-complement offset. The nanoseconds are adjusted one cycle after the command and the seconds one cycle later. A nanosecond result below zero borrows one second and adds 1e9. The final time equals the old time plus the offset plus 8 ns for every counting cycle.
- R9: When load and step are set in the same command word, only the load takes effect. Load and step commands are ignored while a step is still in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Command register write strobe |
| ctl_wdata | input | 16 | Command word |
| tdat_we | input | 1 | Time-data register write strobe |
| tdat_wdata | input | 16 | Time-data word to stage |
| tdat_re | input | 1 | Time-data read strobe, advances the index |
| tdat_rdata | output | 16 | Captured word at the current index |
| tod_sec | output | 32 | Live seconds count |
| tod_ns | output | 32 | Live nanoseconds count |
| tod_running | output | 1 | Counting enabled |

## Verification
The assertions assume three things about the inputs:
- Every loaded nanosecond value is already below 1e9.
- The magnitude of a nanosecond step offset is below 1e9, so a single borrow or carry is enough to normalise the result.
- The staged words are not rewritten during the two step cycles, because the offset is read from them while the step is applied.

The stimulus meets all three. It loads only valid nanosecond values and keeps step offsets small. It also waits at least two idle cycles after every step before it touches the data register again.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
    // command word bit positions
    localparam int CMD_HALT = 0;
    localparam int CMD_RUN  = 1;
    localparam int CMD_SNAP = 2;
    localparam int CMD_LOAD = 3;
    localparam int CMD_STEP = 4;
    localparam int CMD_USED = 5;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_STEP_NS  = 2'd1,
        ST_STEP_SEC = 2'd2
    } step_state_e;
endpackage

// File: rtl/ptp_tod_words.sv
module ptp_tod_words #(
    parameter int WORD_W = 16,
    parameter int NS_W   = 32,
    parameter int SEC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              snap_go,
    input  logic [NS_W-1:0]   tod_ns,
    input  logic [SEC_W-1:0]  tod_sec,
    output logic [NS_W-1:0]   stage_ns,
    output logic [SEC_W-1:0]  stage_sec,
    output logic [WORD_W-1:0] rd_word
);
    localparam int NWORDS = (NS_W + SEC_W) / WORD_W;
    localparam int IDX_W  = $clog2(NWORDS);
    localparam int NS_WORDS = NS_W / WORD_W;

    logic [IDX_W-1:0]  idx_q;
    logic [WORD_W-1:0] stage_w [NWORDS];
    logic [WORD_W-1:0] snap_w  [NWORDS];
    logic [NS_W+SEC_W-1:0] live_flat;

    assign live_flat = {tod_sec, tod_ns};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (ctl_we) begin
            idx_q <= '0;
        end else if (wr_en || rd_en) begin
            idx_q <= (idx_q == IDX_W'(NWORDS - 1)) ? '0 : idx_q + 1'b1;
        end
    end

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_w[g] <= '0;
                snap_w[g]  <= '0;
            end else begin
                if (wr_en && !ctl_we && idx_q == IDX_W'(g)) stage_w[g] <= wr_word;
                if (snap_go) snap_w[g] <= live_flat[g*WORD_W +: WORD_W];
            end
        end
        if (g < NS_WORDS) begin : g_ns
            assign stage_ns[g*WORD_W +: WORD_W] = stage_w[g];
        end else begin : g_sec
            assign stage_sec[(g-NS_WORDS)*WORD_W +: WORD_W] = stage_w[g];
        end
    end

    assign rd_word = snap_w[idx_q];

    // R5: a command write always returns the index to word 0
    p_idx_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> idx_q == '0);
    // R7: the capture holds the live time seen at the accepting edge
    p_snap_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        snap_go |=> {snap_w[1], snap_w[0]} == $past(tod_ns));
endmodule

// File: rtl/ptp_tod_core.sv
module ptp_tod_core
    import ptp_tod_pkg::*;
#(
    parameter int NS_W        = 32,
    parameter int SEC_W       = 32,
    parameter int NS_PER_TICK = 8,
    parameter int NS_WRAP     = 1_000_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load_go,
    input  logic             step_go,
    input  logic [NS_W-1:0]  arg_ns,
    input  logic [SEC_W-1:0] arg_sec,
    output logic [NS_W-1:0]  tod_ns,
    output logic [SEC_W-1:0] tod_sec,
    output logic             idle
);
    localparam int SUM_W = NS_W + 2;
    localparam logic signed [SUM_W-1:0] WRAP_S = SUM_W'(NS_WRAP);
    localparam logic [NS_W-1:0] WRAP_U = NS_W'(NS_WRAP);
    localparam logic [NS_W-1:0] TICK_U = NS_W'(NS_PER_TICK);

    step_state_e state_q, state_d;
    logic [NS_W-1:0]  ns_q, ns_d;
    logic [SEC_W-1:0] sec_q, sec_d;
    logic signed [SUM_W-1:0] add_ns, ns_sum;
    logic carry_up, carry_dn;
    logic take_load;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (step_go && !load_go) state_d = ST_STEP_NS;
            ST_STEP_NS:  state_d = ST_STEP_SEC;
            ST_STEP_SEC: state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs of the state machine: next time value
    always_comb begin
        add_ns = '0;
        if (run) add_ns = SUM_W'(NS_PER_TICK);
        if (state_q == ST_STEP_NS) add_ns = add_ns + SUM_W'(signed'(arg_ns));
        ns_sum   = signed'({2'b00, ns_q}) + add_ns;
        carry_up = 1'b0;
        carry_dn = 1'b0;
        ns_d     = ns_sum[NS_W-1:0];
        if (ns_sum < 0) begin
            ns_d     = NS_W'(ns_sum + WRAP_S);
            carry_dn = 1'b1;
        end else if (ns_sum >= WRAP_S) begin
            ns_d     = NS_W'(ns_sum - WRAP_S);
            carry_up = 1'b1;
        end
        sec_d = sec_q;
        if (state_q == ST_STEP_SEC) sec_d = sec_d + arg_sec;
        if (carry_up) sec_d = sec_d + 1'b1;
        if (carry_dn) sec_d = sec_d - 1'b1;
    end

    assign take_load = load_go && (state_q == ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ns_q  <= '0;
            sec_q <= '0;
        end else if (take_load) begin
            ns_q  <= arg_ns;
            sec_q <= arg_sec;
        end else begin
            ns_q  <= ns_d;
            sec_q <= sec_d;
        end
    end

    assign tod_ns  = ns_q;
    assign tod_sec = sec_q;
    assign idle    = (state_q == ST_IDLE);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && state_q == ST_IDLE && !load_go) |=> ($stable(ns_q) && $stable(sec_q)));
    p_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && state_q == ST_IDLE && !load_go && ns_q < WRAP_U - TICK_U)
        |=> ns_q == $past(ns_q) + TICK_U);
    p_ns_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ns_q < WRAP_U);
    p_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && state_q == ST_IDLE && !load_go && ns_q >= WRAP_U - TICK_U)
        |=> sec_q == $past(sec_q) + 1'b1);
    p_step_seq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_STEP_NS |=> state_q == ST_STEP_SEC);
endmodule

// File: rtl/ptp_tod_clock.sv
module ptp_tod_clock
    import ptp_tod_pkg::*;
#(
    parameter int CTL_W       = 16,
    parameter int WORD_W      = 16,
    parameter int NS_W        = 32,
    parameter int SEC_W       = 32,
    parameter int NS_PER_TICK = 8,
    parameter int NS_WRAP     = 1_000_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              tdat_we,
    input  logic [WORD_W-1:0] tdat_wdata,
    input  logic              tdat_re,
    output logic [WORD_W-1:0] tdat_rdata,
    output logic [SEC_W-1:0]  tod_sec,
    output logic [NS_W-1:0]   tod_ns,
    output logic              tod_running
);
    logic cmd_ok, run_q, load_go, step_go, snap_go, core_idle;
    logic [NS_W-1:0]  stage_ns;
    logic [SEC_W-1:0] stage_sec;

    assign cmd_ok  = ctl_we && (ctl_wdata[CTL_W-1:CMD_USED] == '0);
    assign snap_go = cmd_ok && ctl_wdata[CMD_SNAP];
    assign load_go = cmd_ok && ctl_wdata[CMD_LOAD];
    assign step_go = cmd_ok && ctl_wdata[CMD_STEP] && !ctl_wdata[CMD_LOAD];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             run_q <= 1'b0;
        else if (cmd_ok && ctl_wdata[CMD_HALT]) run_q <= 1'b0;
        else if (cmd_ok && ctl_wdata[CMD_RUN])  run_q <= 1'b1;
    end

    ptp_tod_words #(.WORD_W(WORD_W), .NS_W(NS_W), .SEC_W(SEC_W)) u_words (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_we   (ctl_we),
        .wr_en    (tdat_we),
        .rd_en    (tdat_re),
        .wr_word  (tdat_wdata),
        .snap_go  (snap_go),
        .tod_ns   (tod_ns),
        .tod_sec  (tod_sec),
        .stage_ns (stage_ns),
        .stage_sec(stage_sec),
        .rd_word  (tdat_rdata)
    );

    ptp_tod_core #(.NS_W(NS_W), .SEC_W(SEC_W), .NS_PER_TICK(NS_PER_TICK),
                   .NS_WRAP(NS_WRAP)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_q),
        .load_go(load_go),
        .step_go(step_go),
        .arg_ns (stage_ns),
        .arg_sec(stage_sec),
        .tod_ns (tod_ns),
        .tod_sec(tod_sec),
        .idle   (core_idle)
    );

    assign tod_running = run_q;

    // R4: an accepted halt always leaves counting off
    p_halt_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok && ctl_wdata[CMD_HALT]) |=> !tod_running);
    // R9: a step never starts in the cycle a load is accepted
    p_load_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (load_go && core_idle) |=> core_idle);
endmodule

// File: tb/ptp_tod_clock_bench.sv
module ptp_tod_clock_bench;
    localparam logic [15:0] C_HALT = 16'h0001;
    localparam logic [15:0] C_RUN  = 16'h0002;
    localparam logic [15:0] C_SNAP = 16'h0004;
    localparam logic [15:0] C_LOAD = 16'h0008;
    localparam logic [15:0] C_STEP = 16'h0010;

    // {start_sec, start_ns, off_sec, off_ns, exp_sec, exp_ns}
    localparam int NVEC = 7;
    localparam logic [191:0] VEC [NVEC] = '{
        {32'd10, 32'd500, 32'd0, 32'd100, 32'd10, 32'd600},
        {32'd10, 32'd999_999_990, 32'd0, 32'd20, 32'd11, 32'd10},
        {32'd10, 32'd5, 32'd0, 32'hFFFF_FFF6, 32'd9, 32'd999_999_995},
        {32'd10, 32'd5, 32'hFFFF_FFFD, 32'd0, 32'd7, 32'd5},
        {32'h0001_FFFF, 32'd305_419_896, 32'd2, 32'd1000, 32'h0002_0001, 32'd305_420_896},
        {32'd100, 32'd0, 32'd5, 32'hFFFF_FFFF, 32'd104, 32'd999_999_999},
        {32'hFFFF_FFFF, 32'd999_999_999, 32'd0, 32'd1, 32'd0, 32'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_we = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic tdat_we = 1'b0;
    logic [15:0] tdat_wdata = '0;
    logic tdat_re = 1'b0;
    logic [15:0] tdat_rdata;
    logic [31:0] tod_sec, tod_ns;
    logic tod_running;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ptp_tod_clock u_ptp_tod_clock (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .tdat_we(tdat_we), .tdat_wdata(tdat_wdata), .tdat_re(tdat_re),
        .tdat_rdata(tdat_rdata), .tod_sec(tod_sec), .tod_ns(tod_ns),
        .tod_running(tod_running)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge; one rising edge each
    task automatic cmd(input logic [15:0] v);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0; ctl_wdata = '0;
    endtask

    task automatic wr(input logic [15:0] w);
        tdat_we = 1'b1; tdat_wdata = w;
        @(negedge clk);
        tdat_we = 1'b0;
    endtask

    task automatic stage(input logic [31:0] s, input logic [31:0] n);
        wr(n[15:0]); wr(n[31:16]); wr(s[15:0]); wr(s[31:16]);
    endtask

    task automatic read_time(output logic [31:0] s, output logic [31:0] n);
        logic [15:0] w [4];
        cmd(C_SNAP);
        for (int i = 0; i < 4; i++) begin
            w[i] = tdat_rdata;
            tdat_re = 1'b1;
            @(negedge clk);
            tdat_re = 1'b0;
        end
        n = {w[1], w[0]};
        s = {w[3], w[2]};
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] s, n, a, b, v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 sec", tod_sec, 0);
        check("R1 ns", tod_ns, 0);
        check("R1 run", tod_running, 0);
        check("R1 rdata", tdat_rdata, 0);

        // table: load, step while stopped, read back (R6 R8 R3 R7 R5)
        for (int i = 0; i < NVEC; i++) begin
            cmd(16'h0000);
            stage(VEC[i][191:160], VEC[i][159:128]);
            cmd(C_LOAD);
            stage(VEC[i][127:96], VEC[i][95:64]);
            cmd(C_STEP);
            repeat (2) @(negedge clk);
            read_time(s, n);
            check("R8 vec sec", s, VEC[i][63:32]);
            check("R8 vec ns", n, VEC[i][31:0]);
        end

        // R6 load + R3 wrap while running: 3 ticks from 999_999_984
        cmd(16'h0000);
        stage(32'd5, 32'd999_999_984);
        cmd(C_LOAD);
        check("R6 load ns", tod_ns, 32'd999_999_984);
        cmd(C_RUN);
        repeat (2) @(negedge clk);
        cmd(C_HALT);
        check("R3 wrap sec", tod_sec, 32'd6);
        check("R3 wrap ns", tod_ns, 32'd8);

        // R2 tick per cycle
        cmd(C_RUN);
        a = tod_ns;
        @(negedge clk);
        b = tod_ns;
        check("R2 tick", b - a, 32'd8);
        check("R4 run on", tod_running, 1);

        // R4 halt wins over run; R2 hold
        cmd(C_HALT | C_RUN);
        check("R4 halt wins", tod_running, 0);
        a = tod_ns;
        repeat (4) @(negedge clk);
        check("R2 hold", tod_ns, a);

        // R4 reserved bits reject the command
        cmd(16'h0020 | C_RUN);
        check("R4 reserved", tod_running, 0);

        // R5 index wrap: fifth write lands on word 0
        cmd(16'h0000);
        wr(16'h1111); wr(16'h0000); wr(16'h0007); wr(16'h0000); wr(16'h2222);
        cmd(C_LOAD);
        check("R5 wrap ns", tod_ns, 32'h2222);
        check("R5 wrap sec", tod_sec, 32'd7);

        // R9 load and step together: load only
        cmd(16'h0000);
        stage(32'd3, 32'd50);
        cmd(C_LOAD | C_STEP);
        repeat (3) @(negedge clk);
        check("R9 sec", tod_sec, 32'd3);
        check("R9 ns", tod_ns, 32'd50);

        // R8 step while running: 9 ticks + 1000 ns offset
        cmd(16'h0000);
        stage(32'd20, 32'd100);
        cmd(C_LOAD);
        cmd(C_RUN);
        stage(32'd0, 32'd1000);
        cmd(C_STEP);
        repeat (3) @(negedge clk);
        cmd(C_HALT);
        check("R8 run sec", tod_sec, 32'd20);
        check("R8 run ns", tod_ns, 32'd1172);

        // R7 capture while running; R6 load while running
        cmd(C_RUN);
        v = tod_ns;
        read_time(s, n);
        check("R7 snap ns", n, v);
        check("R7 snap sec", s, 32'd20);
        check("R7 live moved", tod_ns, v + 32'd40);
        stage(32'd77, 32'd400);
        cmd(C_LOAD);
        check("R6 run load", tod_ns, 32'd400);
        @(negedge clk);
        check("R6 resume", tod_ns, 32'd408);
        cmd(C_HALT);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule